// File: doc/BRIEF.md
# Ready-Edge Interrupt Controller

This block watches the ready/busy line of a NAND flash device and tells the host when a long operation such as a page program or a block erase has finished. The line is asynchronous to the host clock. It passes through a synchroniser, and a busy-to-ready transition latches an event in a status register. The host clears that status register by writing ones to it.

A mask register holds a per-source enable field and a global enable bit. The registered interrupt output is high while an enabled status bit is set and the global enable is on. A typical driver clears stale status, enables the ready source together with the global bit, starts the operation and sleeps. In its handler it writes zero to the mask, which drops the line without touching the status bit.

Top module: `rdy_irq_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, the mask register reads 0x00 and `irq` is low.
- R2: When `rb_in` goes from 0 (busy) to 1 (ready), status bit 0 reads 1 after the third rising clock edge that follows the change, and not after the second. This holds for the default synchroniser depth of 2.
- R3: A ready-to-busy transition on `rb_in` does not set status bit 0, and neither does holding `rb_in` at a steady level.
- R4: A write to the status register clears bit 0 when `wr_data[0]` is 1 and leaves it unchanged when `wr_data[0]` is 0. Writing 0x0F clears it.
- R5: If a write with `wr_data[0]`=1 to the status register lands in the same cycle as a detected rising edge, status bit 0 stays set.
- R6: The mask register stores bit 7 (global enable) and bits 3:0 (source enables, with bit 0 for the ready source). Bits 6:4 read 0. For example, writing 0xFF reads back 0x8F.
- R7: `irq` is a register. It is high exactly when mask bit 7 is 1 and status bit 0 AND mask bit 0 is 1. It changes at the same clock edge that updates the status or mask register.
- R8: Writing a value with bit 7 clear (for example 0x00) to the mask register drops `irq` at that write's clock edge, even while status bit 0 stays set.
- R9: Status bits 7:1 always read 0, whatever is written and whatever events occur.
- R10: The status register is at address 6 and the mask register at address 7. Writes to any other address change neither register, and reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rb_in | input | 1 | Asynchronous ready/busy line, 1 = ready |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (3) | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request, active high |

## Verification
A wrong status bit shows at the ports at once: the status read-back returns it in the cycle it exists, and `irq` follows it at the same edge whenever the mask allows. A wrong synchroniser or edge-detector state shows one edge early or late, or as an event on the wrong polarity. The bench therefore samples status in the cycle just before and just after the expected edge. A lost event in the clear-versus-set race reads back as zero one cycle after the write.

// File: rtl/rdy_irq_ctrl.sv
module rdy_irq_ctrl #(
  parameter int ADDR_W      = 3,
  parameter int STAT_ADDR   = 6,
  parameter int MASK_ADDR   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rb_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              irq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;
  logic          rise_evt;
  logic          stat_q, stat_nxt;
  logic          mask_en_q, mask_en_nxt;
  logic [3:0]    mask_src_q, mask_src_nxt;
  logic          wr_stat, wr_mask;
  logic          wr_data_unused;

  assign wr_data_unused = ^wr_data[6:4];
  assign wr_stat  = wr_en && (addr == ADDR_W'(STAT_ADDR));
  assign wr_mask  = wr_en && (addr == ADDR_W'(MASK_ADDR));
  assign rise_evt = sync_q[LAST] && !prev_q;

  assign stat_nxt     = (stat_q && !(wr_stat && wr_data[0])) || rise_evt;
  assign mask_en_nxt  = wr_mask ? wr_data[7]   : mask_en_q;
  assign mask_src_nxt = wr_mask ? wr_data[3:0] : mask_src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q     <= '1;
      prev_q     <= 1'b1;
      stat_q     <= 1'b0;
      mask_en_q  <= 1'b0;
      mask_src_q <= '0;
      irq        <= 1'b0;
    end else begin
      sync_q     <= {sync_q[LAST-1:0], rb_in};
      prev_q     <= sync_q[LAST];
      stat_q     <= stat_nxt;
      mask_en_q  <= mask_en_nxt;
      mask_src_q <= mask_src_nxt;
      irq        <= mask_en_nxt && stat_nxt && mask_src_nxt[0];
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (addr == ADDR_W'(STAT_ADDR))      rd_data = {7'b0, stat_q};
    else if (addr == ADDR_W'(MASK_ADDR)) rd_data = {mask_en_q, 3'b0, mask_src_q};
  end
endmodule

module rdy_irq_ctrl_chk #(
  parameter int ADDR_W    = 3,
  parameter int STAT_ADDR = 6,
  parameter int MASK_ADDR = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wr_data,
  input logic              rise_evt,
  input logic              stat_q,
  input logic              mask_en_q,
  input logic [3:0]        mask_src_q,
  input logic              irq
);
  assert_only_rise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(rise_evt));

  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(STAT_ADDR) && wr_data[0] && !rise_evt) |=> !stat_q);

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> stat_q);

  assert_irq_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (mask_en_q && stat_q && mask_src_q[0]));

  assert_global_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(MASK_ADDR) && !wr_data[7]) |=> !irq);

  assert_other_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != ADDR_W'(STAT_ADDR) && addr != ADDR_W'(MASK_ADDR))
      |=> $stable({mask_en_q, mask_src_q}));
endmodule

bind rdy_irq_ctrl rdy_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rise_evt(rise_evt), .stat_q(stat_q), .mask_en_q(mask_en_q),
  .mask_src_q(mask_src_q), .irq(irq)
);

// File: tb/test_rdy_irq_ctrl.sv
module test_rdy_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_STAT = 3'd6;
  localparam logic [2:0] A_MASK = 3'd7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rb_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdy_irq_ctrl i_rdy_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .rb_in(rb_in), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_ready();
    @(negedge clk); rb_in = 1'b0;
    cycles(4);
    rb_in = 1'b1;
    cycles(3);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(A_STAT, v); check("R1 status", v, 8'h00);
    rd(A_MASK, v); check("R1 mask", v, 8'h00);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_edge_timing();
    logic [7:0] v;
    cycles(4);
    rb_in = 1'b1;
    cycles(2);
    rd(A_STAT, v); check("R2 not yet after 2nd edge", v, 8'h00);
    cycles(1);
    rd(A_STAT, v); check("R2 set after 3rd edge", v, 8'h01);
    check("R7 irq low with mask clear", irq, 0);
  endtask

  task automatic t_no_false_event();
    logic [7:0] v;
    wr(A_STAT, 8'h0F);
    cycles(5);
    rd(A_STAT, v); check("R3 steady high no event", v, 8'h00);
    rb_in = 1'b0;
    cycles(6);
    rd(A_STAT, v); check("R3 falling edge no event", v, 8'h00);
  endtask

  task automatic t_w1c();
    logic [7:0] v;
    pulse_ready();
    wr(A_STAT, 8'h00);
    rd(A_STAT, v); check("R4 zero write keeps", v, 8'h01);
    wr(A_STAT, 8'h0E);
    rd(A_STAT, v); check("R4 bit0 clear keeps", v, 8'h01);
    wr(A_STAT, 8'h0F);
    rd(A_STAT, v); check("R4 0x0F clears", v, 8'h00);
  endtask

  task automatic t_race();
    logic [7:0] v;
    @(negedge clk); rb_in = 1'b0;
    cycles(4);
    rb_in = 1'b1;
    cycles(2);
    wr_en = 1'b1; addr = A_STAT; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    rd(A_STAT, v); check("R5 event survives clear", v, 8'h01);
    wr(A_STAT, 8'h01);
    rd(A_STAT, v); check("R5 later clear works", v, 8'h00);
  endtask

  task automatic t_mask_fields();
    logic [7:0] v;
    wr(A_MASK, 8'hFF);
    rd(A_MASK, v); check("R6 reserved bits zero", v, 8'h8F);
    wr(A_MASK, 8'h01);
    rd(A_MASK, v); check("R6 source only", v, 8'h01);
    wr(A_MASK, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(A_MASK, 8'h81);
    check("R7 no status no irq", irq, 0);
    @(negedge clk); rb_in = 1'b0;
    cycles(4);
    rb_in = 1'b1;
    cycles(2);
    check("R7 irq not before status", irq, 0);
    cycles(1);
    check("R7 irq with status", irq, 1);
    wr(A_MASK, 8'h01);
    check("R7 needs global enable", irq, 0);
    wr(A_MASK, 8'h80);
    check("R7 needs source enable", irq, 0);
    wr(A_MASK, 8'h81);
    check("R7 re-enabled", irq, 1);
    wr(A_MASK, 8'h00);
    check("R8 mask off drops irq", irq, 0);
    rd(A_STAT, v); check("R8 status still set", v, 8'h01);
    wr(A_MASK, 8'h81);
    check("R7 back on", irq, 1);
    wr(A_STAT, 8'h0F);
    check("R7 clear drops irq", irq, 0);
    wr(A_MASK, 8'h00);
  endtask

  task automatic t_reserved_status();
    logic [7:0] v;
    wr(A_STAT, 8'hFE);
    rd(A_STAT, v); check("R9 reserved write", v, 8'h00);
    pulse_ready();
    rd(A_STAT, v); check("R9 only bit0 set", v, 8'h01);
    wr(A_STAT, 8'h0F);
  endtask

  task automatic t_addr_decode();
    logic [7:0] v;
    wr(A_MASK, 8'h81);
    for (int a = 0; a < 6; a++) wr(3'(a), 8'h00);
    rd(A_MASK, v); check("R10 mask untouched", v, 8'h81);
    pulse_ready();
    for (int a = 0; a < 6; a++) wr(3'(a), 8'hFF);
    rd(A_STAT, v); check("R10 status untouched", v, 8'h01);
    rd(3'd3, v); check("R10 other address reads 0", v, 8'h00);
    wr(A_STAT, 8'h0F);
    wr(A_MASK, 8'h00);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    t_reset();
    t_edge_timing();
    t_no_false_event();
    t_w1c();
    t_race();
    t_mask_fields();
    t_irq();
    t_reserved_status();
    t_addr_decode();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule